// File: doc/BRIEF.md
# Third-Order Sinc Decimator with Filter Sync

This block turns a one-bit oversampled bitstream into 16-bit words. Three integrators run at the input sample rate and three differentiators run at the decimated rate. Together they give a sinc-cubed response whose first notch sits at the output word rate. The decimation ratio is a power of two, chosen by a three-bit rate select and a range bit. Input samples are taken only on cycles where the master-clock enable is high. An optional halving mode uses only every second enabled cycle.

A filter-sync input holds the integrators, the differentiators, the ratio counter and the settle tracking at zero. After it is released, the first word comes out exactly three output periods later. That word already covers a full filter window. The block raises a one-cycle strobe with each new word and keeps a ready flag high until the reader acknowledges the word. The sync input does not clear a ready flag that is already set.

Top module: `sinc3_decim`

## Requirements
- R1: After reset, `word_out` is 0 and both `word_strobe` and `word_ready` are low.
- R2: A bit value of 1 counts as a full-scale sample and 0 counts as zero. For a bitstream that repeats with a period of 8 samples and holds k ones per period, every settled word equals 8192·k. All ones (k = 8) saturates to 16'hFFFF.
- R3: The decimation ratio is 2^(6 + rate_sel + rate_hi) samples. Settled strobes come exactly that many samples apart.
- R4: A sample is taken only on a clock where `mclk_en` is high. With `half_clk` = 1, only every second such clock takes a sample.
- R5: While `sync_hold` is high, and on the cycle after it falls, no strobe is raised. The first strobe comes 3·ratio samples after release and already carries the settled value.
- R6: Holding `sync_hold` high leaves a set `word_ready` unchanged.
- R7: `word_ready` rises together with `word_strobe`. An acknowledge clears it on the next cycle unless a new word arrives in that same cycle, in which case the flag stays set.
- R8: After an input change that is not tied to a sync release, the fourth word that follows the change holds the new settled value.
- R9: `word_out` changes only in cycles where `word_strobe` is high. It keeps its value while sync is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mclk_en | input | 1 | Master-clock enable; qualifies input samples |
| half_clk | input | 1 | 1: use every second enabled clock |
| rate_sel | input | 3 | Ratio exponent offset |
| rate_hi | input | 1 | Adds one to the ratio exponent |
| sync_hold | input | 1 | Holds the filter datapath at zero |
| bit_in | input | 1 | Modulator bitstream |
| word_ack | input | 1 | Reader acknowledge; clears the ready flag |
| word_out | output | 16 | Latest filtered word |
| word_strobe | output | 1 | One-cycle pulse with each new word |
| word_ready | output | 1 | Set by a new word, cleared by acknowledge |

## Verification
A word is registered on the clock that takes the last sample of an output period. The strobe, the word and the ready flag are therefore visible from that edge on. After a release on a falling edge, with one sample per clock, the bench expects the first strobe at the 3·ratio-th following falling edge and later strobes exactly one ratio apart. For a step change it counts strobes and checks the fourth. The bench samples every output on the falling edge, so each result is read half a cycle after the edge that produced it. Acknowledge and sync are likewise driven on falling edges, and their effect is read one falling edge later.

// File: rtl/sinc3_pkg.sv
package sinc3_pkg;

    localparam int OUT_W = 16;
    localparam int ORDER = 3;

    typedef logic [OUT_W-1:0] word_t;

    typedef struct packed {
        logic  strobe;
        logic  ready;
        word_t word;
    } out_t;

    // accumulator width for a largest ratio exponent
    function automatic int acc_width(input int log_max);
        return ORDER * log_max + 1;
    endfunction

    // clip an already shifted value to the output word
    function automatic word_t clip_word(input logic [63:0] v);
        if (|v[63:OUT_W]) return '1;
        return v[OUT_W-1:0];
    endfunction

endpackage

// File: rtl/sinc3_tick_gen.sv
module sinc3_tick_gen (
    input  logic clk,
    input  logic rst,
    input  logic mclk_en,
    input  logic half_clk,
    output logic tick
);
    logic phase_q;

    always_ff @(posedge clk) begin
        if (rst)          phase_q <= 1'b0;
        else if (mclk_en) phase_q <= half_clk ? ~phase_q : 1'b0;
    end

    assign tick = mclk_en & (~half_clk | phase_q);
endmodule

// File: rtl/sinc3_rate_ctr.sv
module sinc3_rate_ctr #(
    parameter int LOG_MIN = 6,
    parameter int SEL_W   = 3,
    localparam int LOG_MAX = LOG_MIN + 2**SEL_W,
    localparam int LW      = $clog2(LOG_MAX + 1)
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             tick,
    input  logic [SEL_W-1:0] rate_sel,
    input  logic             rate_hi,
    output logic [LW-1:0]    log2r,
    output logic             dec
);
    logic [LOG_MAX-1:0] cnt_q, lim;
    logic               last;

    assign log2r = LW'(LOG_MIN) + LW'(rate_sel) + LW'(rate_hi);
    assign lim   = (LOG_MAX'(1) << log2r) - LOG_MAX'(1);
    assign last  = (cnt_q == lim);
    assign dec   = tick & last & ~clr;

    always_ff @(posedge clk) begin
        if (clr)       cnt_q <= '0;
        else if (tick) cnt_q <= last ? '0 : cnt_q + LOG_MAX'(1);
    end
endmodule

// File: rtl/sinc3_integ.sv
module sinc3_integ #(
    parameter int ACC_W = 43,
    parameter int ORDER = 3
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             tick,
    input  logic             bit_in,
    output logic [ACC_W-1:0] sum_out
);
    for (genvar g = 0; g < ORDER; g++) begin : stg
        logic [ACC_W-1:0] q, sum;
        if (g == 0) begin : g_first
            assign sum = q + ACC_W'(bit_in);
        end else begin : g_rest
            assign sum = q + stg[g-1].sum;
        end
        always_ff @(posedge clk) begin
            if (clr)       q <= '0;
            else if (tick) q <= sum;
        end
    end

    assign sum_out = stg[ORDER-1].sum;
endmodule

// File: rtl/sinc3_comb.sv
module sinc3_comb #(
    parameter int ACC_W = 43,
    parameter int ORDER = 3
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             dec,
    input  logic [ACC_W-1:0] din,
    output logic [ACC_W-1:0] dout
);
    for (genvar g = 0; g < ORDER; g++) begin : stg
        logic [ACC_W-1:0] dly, inp, diff;
        if (g == 0) begin : g_first
            assign inp = din;
        end else begin : g_rest
            assign inp = stg[g-1].diff;
        end
        assign diff = inp - dly;
        always_ff @(posedge clk) begin
            if (clr)      dly <= '0;
            else if (dec) dly <= inp;
        end
    end

    assign dout = stg[ORDER-1].diff;
endmodule

// File: rtl/sinc3_decim.sv
module sinc3_decim
    import sinc3_pkg::*;
#(
    parameter int LOG_MIN = 6,
    parameter int SEL_W   = 3,
    localparam int LOG_MAX = LOG_MIN + 2**SEL_W,
    localparam int LW      = $clog2(LOG_MAX + 1),
    localparam int ACC_W   = acc_width(LOG_MAX)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mclk_en,
    input  logic             half_clk,
    input  logic [SEL_W-1:0] rate_sel,
    input  logic             rate_hi,
    input  logic             sync_hold,
    input  logic             bit_in,
    input  logic             word_ack,
    output logic [OUT_W-1:0] word_out,
    output logic             word_strobe,
    output logic             word_ready
);
    logic             clr, tick, dec, valid;
    logic [LW-1:0]    log2r;
    logic [ACC_W-1:0] integ_sum, comb_out;
    logic [7:0]       shamt;
    logic [1:0]       settle_q;
    word_t            scaled;
    out_t             out_q;

    assign clr = rst | sync_hold;

    sinc3_tick_gen u_tick (
        .clk(clk), .rst(rst), .mclk_en(mclk_en), .half_clk(half_clk), .tick(tick)
    );

    sinc3_rate_ctr #(.LOG_MIN(LOG_MIN), .SEL_W(SEL_W)) u_rate (
        .clk(clk), .clr(clr), .tick(tick), .rate_sel(rate_sel),
        .rate_hi(rate_hi), .log2r(log2r), .dec(dec)
    );

    sinc3_integ #(.ACC_W(ACC_W), .ORDER(ORDER)) u_integ (
        .clk(clk), .clr(clr), .tick(tick), .bit_in(bit_in), .sum_out(integ_sum)
    );

    sinc3_comb #(.ACC_W(ACC_W), .ORDER(ORDER)) u_comb (
        .clk(clk), .clr(clr), .dec(dec), .din(integ_sum), .dout(comb_out)
    );

    // drop the low bits that exceed the output width at this ratio
    assign shamt  = 8'(ORDER * int'(log2r)) - 8'(OUT_W);
    assign scaled = clip_word(64'(comb_out) >> shamt);

    // words before the third decimation do not span a full window
    assign valid = dec & settle_q[1];

    always_ff @(posedge clk) begin
        if (clr)                       settle_q <= '0;
        else if (dec && !settle_q[1])  settle_q <= settle_q + 2'd1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else begin
            out_q.strobe <= valid;
            if (valid)         out_q.word  <= scaled;
            if (valid)         out_q.ready <= 1'b1;
            else if (word_ack) out_q.ready <= 1'b0;
        end
    end

    assign word_out    = out_q.word;
    assign word_strobe = out_q.strobe;
    assign word_ready  = out_q.ready;
endmodule

// File: rtl/sinc3_decim_chk.sv
module sinc3_decim_chk (
    input logic        clk,
    input logic        rst,
    input logic        sync_hold,
    input logic        word_ack,
    input logic        word_strobe,
    input logic        word_ready,
    input logic [15:0] word_out
);
    // R5: no word while the filter is held in sync
    p_sync_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        $past(sync_hold) |-> !word_strobe);

    // R6: a set ready flag survives anything but an acknowledge
    p_ready_hold_r6: assert property (@(posedge clk) disable iff (rst)
        word_ready && !word_ack |=> word_ready);

    // R7: a new word always shows as ready
    p_ready_with_word_r7: assert property (@(posedge clk) disable iff (rst)
        word_strobe |-> word_ready);

    // R7: after an acknowledge only a fresh word keeps the flag up
    p_ack_clear_r7: assert property (@(posedge clk) disable iff (rst)
        word_ack |=> (word_ready == word_strobe));

    // R9: the word moves only with a strobe
    p_word_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !word_strobe |-> $stable(word_out));
endmodule

bind sinc3_decim sinc3_decim_chk u_chk (
    .clk(clk), .rst(rst), .sync_hold(sync_hold), .word_ack(word_ack),
    .word_strobe(word_strobe), .word_ready(word_ready), .word_out(word_out)
);

// File: tb/sinc3_decim_test.sv
module sinc3_decim_test;
    localparam int CLK_PERIOD = 10;
    localparam int LIMIT      = 20000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mclk_en = 1'b1;
    logic        half_clk = 1'b0;
    logic [2:0]  rate_sel = '0;
    logic        rate_hi = 1'b0;
    logic        sync_hold = 1'b1;
    logic        word_ack = 1'b0;
    logic        en_mode = 1'b0;
    logic [7:0]  pat = 8'h00;
    logic [2:0]  idx = '0;
    logic        bit_in;
    logic [15:0] word_out;
    logic        word_strobe, word_ready;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign bit_in = pat[idx];
    always @(posedge clk) if (mclk_en) idx <= idx + 3'd1;
    always @(negedge clk) mclk_en <= en_mode ? ~mclk_en : 1'b1;

    sinc3_decim uut (
        .clk(clk), .rst(rst), .mclk_en(mclk_en), .half_clk(half_clk),
        .rate_sel(rate_sel), .rate_hi(rate_hi), .sync_hold(sync_hold),
        .bit_in(bit_in), .word_ack(word_ack), .word_out(word_out),
        .word_strobe(word_strobe), .word_ready(word_ready)
    );

    function automatic logic [15:0] exp_word(input logic [7:0] p);
        int k = $countones(p);
        if (k == 8) return 16'hFFFF;
        return 16'(k * 8192);
    endfunction

    function automatic int ratio(input int s, input int h);
        return 1 << (6 + s + h);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic restart(input int s, input int h, input bit hc, input logic [7:0] p);
        @(negedge clk);
        sync_hold = 1'b1;
        rate_sel  = 3'(s);
        rate_hi   = h[0];
        half_clk  = hc;
        pat       = p;
        repeat (4) @(negedge clk);
        sync_hold = 1'b0;
    endtask

    task automatic wait_strobe(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!word_strobe && n < LIMIT);
    endtask

    initial begin
        int n, r;
        logic [7:0] p;
        logic [15:0] held;
        bit seen;
        void'($urandom(32'd4242));

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(word_out == 0 && !word_ready && !word_strobe, "R1 reset",
              {word_out, 6'd0, word_ready, word_strobe}, 0);

        // directed extremes and a mid scale at the smallest ratio
        foreach (p_list[i]) begin end
        for (int i = 0; i < 3; i++) begin
            p = (i == 0) ? 8'hFF : (i == 1) ? 8'h00 : 8'h0F;
            restart(0, 0, 1'b0, p);
            wait_strobe(n);
            check(n == 192, "R5 first word delay", n, 192);
            check(word_out == exp_word(p), "R5 first word value", word_out, exp_word(p));
            wait_strobe(n);
            check(word_out == exp_word(p), "R2 settled word", word_out, exp_word(p));
        end

        // ratio table
        for (int i = 0; i < 4; i++) begin
            int s = (i == 3) ? 2 : (i >= 1 ? 1 : 0);
            int h = (i >= 2) ? 1 : 0;
            restart(s, h, 1'b0, 8'h3F);
            wait_strobe(n);
            wait_strobe(n);
            check(n == ratio(s, h), "R3 strobe spacing", n, ratio(s, h));
            check(word_out == exp_word(8'h3F), "R2 word at ratio", word_out, exp_word(8'h3F));
        end

        // halved clock and sparse enable
        restart(0, 0, 1'b1, 8'h33);
        wait_strobe(n);
        wait_strobe(n);
        check(n == 128, "R4 half clock spacing", n, 128);
        check(word_out == 16'h8000, "R4 half clock word", word_out, 16'h8000);
        en_mode = 1'b1;
        restart(0, 0, 1'b0, 8'h5A);
        wait_strobe(n);
        wait_strobe(n);
        check(n == 128, "R4 sparse enable spacing", n, 128);
        check(word_out == 16'h8000, "R4 sparse enable word", word_out, 16'h8000);
        en_mode = 1'b0;

        // unsynchronised step
        restart(0, 0, 1'b0, 8'h0F);
        wait_strobe(n);
        r = 1 + int'($urandom % 60);
        repeat (r) @(negedge clk);
        pat = 8'h01;
        for (int i = 0; i < 4; i++) wait_strobe(n);
        check(word_out == 16'h2000, "R8 fourth word after step", word_out, 16'h2000);

        // ready flag: clear, then acknowledge coinciding with a new word
        @(negedge clk);
        word_ack = 1'b1;
        @(negedge clk);
        word_ack = 1'b0;
        check(!word_ready, "R7 ack clears ready", word_ready, 0);
        restart(0, 0, 1'b0, 8'h07);
        repeat (191) @(negedge clk);
        word_ack = 1'b1;
        @(negedge clk);
        word_ack = 1'b0;
        check(word_strobe && word_ready, "R7 new word beats ack",
              {word_strobe, word_ready}, 3);

        // sync held with ready set
        held = word_out;
        seen = 1'b0;
        @(negedge clk);
        sync_hold = 1'b1;
        pat = 8'hFF;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (word_strobe) seen = 1'b1;
        end
        check(word_ready, "R6 ready kept under sync", word_ready, 1);
        check(!seen, "R5 no strobe under sync", seen, 0);
        check(word_out == held, "R9 word kept under sync", word_out, held);
        sync_hold = 1'b0;

        // constrained random patterns and ratios
        for (int it = 0; it < 10; it++) begin
            int s = int'($urandom % 3);
            int h = int'($urandom % 2);
            p = 8'($urandom);
            restart(s, h, 1'b0, p);
            wait_strobe(n);
            check(n == 3 * ratio(s, h), "R5 random first delay", n, 3 * ratio(s, h));
            check(word_out == exp_word(p), "R2 random first word", word_out, exp_word(p));
            held = word_out;
            wait_strobe(n);
            check(n == ratio(s, h), "R3 random spacing", n, ratio(s, h));
            check(word_out == exp_word(p), "R2 random second word", word_out, exp_word(p));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    logic [7:0] p_list [1];

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule